// File: doc/BRIEF.md
# Variable-Length Instruction Decoder

This block is the front end of a small 16-bit register CPU. It pulls words from an instruction memory that has a one-cycle synchronous read port. It splits the first word of each instruction into its fields. When needed, it fetches a second word that holds a 10-bit extended opcode, a literal word, or both. It then hands the execute stage one fully resolved instruction: the opcode, the destination index, the source operand value and the length in words.

The source operand is resolved inside the block in one of three ways:
- through a combinational register-file read port;
- from the program counter, which is kept here;
- from a short literal packed into the source field, or from a literal taken from the instruction stream.

The decoded result is held under a valid/ready handshake. No word is fetched while the execute stage stalls.

Top module: `instr_decoder`

## Requirements
- R1: The first instruction word is split as source = bits [15:10], destination = bits [9:6] and basic opcode = bits [5:0]. The destination and opcode appear unchanged on `dec_dst` and `dec_opcode`.
- R2: Source codes 0x00–0x0D and 0x0F drive `reg_sel` with the low four bits of the code, and `dec_src` is the value returned on `reg_rdata`. Source code 0x0E yields the program counter value that follows the last word of the instruction.
- R3: Source code 0x10 takes the operand from the next word in the stream. For a basic opcode this makes a 2-word instruction.
- R4: Source code 0x11 yields 0xFFFF. Codes 0x12 to 0x3F yield the code minus 0x12, which covers 0x0000 to 0x002D.
- R5: Every read is issued at the current program counter (`imem_addr`), and the counter then advances by exactly one. Without a read the address does not change. After an instruction is presented, `imem_addr` equals its start address plus its length.
- R6: A basic opcode of 0x00 marks a non-basic instruction. Bits [15:6] of the following word appear on `dec_ext_op`. With source 0x10 the literal follows that extension word, which makes 3 words. For basic instructions `dec_ext_op` reads 0.
- R7: An extension word whose bits [5:0] are not all zero raises `err_illegal` for exactly one cycle, once per such instruction. A well-formed extension word raises no pulse.
- R8: `dec_valid` stays high, and every decoded output stays stable, until `dec_ready` is sampled high. No memory read is issued while the result waits.
- R9: `dec_unimpl` is 1 for every non-basic instruction and for basic opcodes 0x13 to 0x3A. It is 0 for basic opcodes 0x01–0x12 and 0x3B–0x3F.
- R10: `dec_len` gives the instruction length as 1, 2 or 3.
- R11: While reset is asserted, `dec_valid` and `err_illegal` are 0 and `imem_addr` equals the reset start address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_rd | output | 1 | Instruction memory read strobe |
| imem_addr | output | AW | Read address (the program counter) |
| imem_rdata | input | 16 | Read data, valid the cycle after `imem_rd` |
| reg_sel | output | 4 | Register file read index |
| reg_rdata | input | 16 | Register file read data (combinational) |
| dec_valid | output | 1 | Decoded instruction available |
| dec_ready | input | 1 | Execute stage accepts the instruction |
| dec_opcode | output | 6 | Basic opcode field (0 for non-basic) |
| dec_ext_op | output | 10 | Extended opcode of a non-basic instruction |
| dec_dst | output | 4 | Destination register index |
| dec_src | output | 16 | Resolved source operand value |
| dec_len | output | 2 | Instruction length in words |
| dec_unimpl | output | 1 | Opcode is reserved or extended |
| err_illegal | output | 1 | One-cycle pulse for a malformed extension word |

## Verification
The embedded assertions watch several behaviours on every cycle:
- the counter advancing by one per read and holding otherwise;
- the decoded outputs staying frozen while the handshake stalls, with no read issued;
- the error pulse lasting a single cycle;
- the length staying within 1 to 3, and non-basic instructions being at least 2 words.

Only the directed scenarios can show the value-level results:
- field extraction and the short-literal mapping at both ends of its range;
- the program counter value for source 0x0E;
- the literal placed after the extension word;
- the unimplemented classification;
- exactly one error pulse per malformed instruction.

// File: rtl/instr_decoder.sv
module instr_decoder #(
  parameter int AW       = 16,
  parameter int RESET_PC = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic          imem_rd,
  output logic [AW-1:0] imem_addr,
  input  logic [15:0]   imem_rdata,
  output logic [3:0]    reg_sel,
  input  logic [15:0]   reg_rdata,
  output logic          dec_valid,
  input  logic          dec_ready,
  output logic [5:0]    dec_opcode,
  output logic [9:0]    dec_ext_op,
  output logic [3:0]    dec_dst,
  output logic [15:0]   dec_src,
  output logic [1:0]    dec_len,
  output logic          dec_unimpl,
  output logic          err_illegal
);

  localparam logic [5:0] SRC_INLINE = 6'h10;
  localparam logic [5:0] SRC_MINUS1 = 6'h11;
  localparam logic [5:0] SRC_ZERO   = 6'h12;
  localparam logic [3:0] IDX_PC     = 4'hE;
  localparam logic [5:0] RSV_LO     = 6'h13;
  localparam logic [5:0] RSV_HI     = 6'h3A;

  typedef enum logic [2:0] {S_FETCH, S_WORD1, S_EXT, S_LIT, S_PRESENT} state_t;

  state_t        state;
  logic [AW-1:0] pc;
  logic [5:0]    w1_src;
  logic [5:0]    in_src, in_op, cur_src;
  logic          need_more;

  assign in_src    = imem_rdata[15:10];
  assign in_op     = imem_rdata[5:0];
  assign need_more = (in_op == 6'h00) || (in_src == SRC_INLINE);
  assign cur_src   = (state == S_WORD1) ? in_src : w1_src;
  assign reg_sel   = cur_src[3:0];
  assign imem_addr = pc;
  assign dec_valid = (state == S_PRESENT);

  assign imem_rd = (state == S_FETCH)
                || (state == S_WORD1 && need_more)
                || (state == S_EXT && w1_src == SRC_INLINE)
                || (state == S_PRESENT && dec_ready);

  assign dec_unimpl = (dec_opcode == 6'h00)
                   || (dec_opcode >= RSV_LO && dec_opcode <= RSV_HI);

  function automatic logic [15:0] resolve(input logic [5:0] code,
                                          input logic [15:0] rv,
                                          input logic [AW-1:0] pcv);
    if (code < SRC_INLINE)
      resolve = (code[3:0] == IDX_PC) ? 16'(pcv) : rv;
    else if (code == SRC_MINUS1)
      resolve = 16'hFFFF;
    else
      resolve = 16'(code - SRC_ZERO);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_FETCH;
      pc          <= AW'(RESET_PC);
      w1_src      <= '0;
      dec_opcode  <= '0;
      dec_ext_op  <= '0;
      dec_dst     <= '0;
      dec_src     <= '0;
      dec_len     <= 2'd1;
      err_illegal <= 1'b0;
    end else begin
      err_illegal <= 1'b0;
      if (imem_rd) pc <= pc + 1'b1;
      case (state)
        S_FETCH: state <= S_WORD1;
        S_WORD1: begin
          w1_src     <= in_src;
          dec_dst    <= imem_rdata[9:6];
          dec_opcode <= in_op;
          dec_ext_op <= '0;
          if (in_op == 6'h00) begin
            dec_len <= 2'd2;
            state   <= S_EXT;
          end else if (in_src == SRC_INLINE) begin
            dec_len <= 2'd2;
            state   <= S_LIT;
          end else begin
            dec_len <= 2'd1;
            dec_src <= resolve(in_src, reg_rdata, pc);
            state   <= S_PRESENT;
          end
        end
        S_EXT: begin
          dec_ext_op  <= imem_rdata[15:6];
          err_illegal <= |imem_rdata[5:0];
          if (w1_src == SRC_INLINE) begin
            dec_len <= 2'd3;
            state   <= S_LIT;
          end else begin
            dec_src <= resolve(w1_src, reg_rdata, pc);
            state   <= S_PRESENT;
          end
        end
        S_LIT: begin
          dec_src <= imem_rdata;
          state   <= S_PRESENT;
        end
        S_PRESENT: if (dec_ready) state <= S_WORD1;
        default: state <= S_FETCH;
      endcase
    end
  end

  // R5
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    imem_rd |=> imem_addr == $past(imem_addr) + 1'b1);

  // R5
  pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !imem_rd |=> $stable(imem_addr));

  // R8
  hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid && !dec_ready |=> dec_valid && $stable(dec_src) && $stable(dec_dst)
      && $stable(dec_opcode) && $stable(dec_ext_op) && $stable(dec_len));

  // R8
  stall_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid && !dec_ready |-> !imem_rd);

  // R7
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_illegal |=> !err_illegal);

  // R10
  len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> dec_len >= 2'd1);

  // R6
  nonbasic_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid && dec_opcode == 6'h00 |-> dec_len >= 2'd2 && dec_unimpl);

endmodule

// File: tb/instr_decoder_test.sv
module instr_decoder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        imem_rd;
  logic [15:0] imem_addr;
  logic [15:0] imem_rdata;
  logic [3:0]  reg_sel;
  logic [15:0] reg_rdata;
  logic        dec_valid;
  logic        dec_ready = 1'b0;
  logic [5:0]  dec_opcode;
  logic [9:0]  dec_ext_op;
  logic [3:0]  dec_dst;
  logic [15:0] dec_src;
  logic [1:0]  dec_len;
  logic        dec_unimpl;
  logic        err_illegal;

  int checks = 0;
  int fails = 0;
  int err_cnt = 0;
  logic [15:0] mem [0:31];

  always #4 clk = ~clk;

  instr_decoder #(.AW(16), .RESET_PC(0)) uut (
    .clk(clk), .rst_n(rst_n), .imem_rd(imem_rd), .imem_addr(imem_addr),
    .imem_rdata(imem_rdata), .reg_sel(reg_sel), .reg_rdata(reg_rdata),
    .dec_valid(dec_valid), .dec_ready(dec_ready), .dec_opcode(dec_opcode),
    .dec_ext_op(dec_ext_op), .dec_dst(dec_dst), .dec_src(dec_src),
    .dec_len(dec_len), .dec_unimpl(dec_unimpl), .err_illegal(err_illegal));

  always_ff @(posedge clk) if (imem_rd) imem_rdata <= mem[imem_addr[4:0]];
  assign reg_rdata = 16'hA000 + 16'(reg_sel);

  always @(negedge clk) if (err_illegal) err_cnt++;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_valid();
    for (int i = 0; i < 60 && !dec_valid; i++) @(negedge clk);
    check(dec_valid, "R8 valid timeout", dec_valid, 1);
  endtask

  task automatic accept();
    dec_ready = 1'b1;
    @(negedge clk);
    dec_ready = 1'b0;
  endtask

  task automatic expect_instr(input string tag, input int start, input int len,
                              input int dst, input int op, input int ext,
                              input logic [15:0] val, input bit unimpl);
    wait_valid();
    check(dec_len == 2'(len), {tag, " R10 len"}, dec_len, len);
    check(dec_dst == 4'(dst), {tag, " R1 dst"}, dec_dst, dst);
    check(dec_opcode == 6'(op), {tag, " R1 opcode"}, dec_opcode, op);
    check(dec_ext_op == 10'(ext), {tag, " R6 ext"}, dec_ext_op, ext);
    check(dec_src == val, {tag, " src value"}, dec_src, val);
    check(dec_unimpl == unimpl, {tag, " R9 unimpl"}, dec_unimpl, unimpl);
    check(imem_addr == 16'(start + len), {tag, " R5 pc"}, imem_addr, start + len);
    accept();
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(!dec_valid, "R11 valid in reset", dec_valid, 0);
    check(!err_illegal, "R11 err in reset", err_illegal, 0);
    check(imem_addr == 16'h0, "R11 pc in reset", imem_addr, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_basic();
    expect_instr("R2 reg", 0, 1, 0, 6'h01, 0, 16'hA001, 0);
    expect_instr("R3 inline", 1, 2, 2, 6'h02, 0, 16'h1234, 0);
    expect_instr("R4 minus1", 3, 1, 6, 6'h03, 0, 16'hFFFF, 0);
    expect_instr("R4 max", 4, 1, 15, 6'h01, 0, 16'h002D, 0);
    expect_instr("R2 pc src", 5, 1, 0, 6'h3F, 0, 16'h0006, 0);
    expect_instr("R9 reserved R4 zero", 6, 1, 0, 6'h20, 0, 16'h0000, 1);
  endtask

  task automatic t_nonbasic();
    expect_instr("R6 ext reg", 7, 2, 1, 6'h00, 10'h155, 16'hA007, 1);
    check(err_cnt == 0, "R7 no pulse when clean", err_cnt, 0);
    expect_instr("R6 ext literal", 9, 3, 0, 6'h00, 10'h3FF, 16'hBEEF, 1);
    expect_instr("R7 illegal", 12, 2, 0, 6'h00, 10'h001, 16'hA001, 1);
    check(err_cnt == 1, "R7 one pulse", err_cnt, 1);
  endtask

  task automatic t_stall();
    logic [15:0] v;
    wait_valid();
    v = dec_src;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(dec_valid && dec_src == v && dec_len == 2'd1, "R8 hold", dec_src, v);
      check(!imem_rd, "R8 no read while stalled", imem_rd, 0);
      check(imem_addr == 16'd15, "R5 pc still", imem_addr, 15);
    end
    accept();
    check(err_cnt == 1, "R7 no extra pulse", err_cnt, 1);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) mem[i] = 16'h0401;
    mem[0]  = 16'h0401; mem[1]  = 16'h4082; mem[2]  = 16'h1234;
    mem[3]  = 16'h4583; mem[4]  = 16'hFFC1; mem[5]  = 16'h383F;
    mem[6]  = 16'h4820; mem[7]  = 16'h1C40; mem[8]  = 16'h5540;
    mem[9]  = 16'h4000; mem[10] = 16'hFFC0; mem[11] = 16'hBEEF;
    mem[12] = 16'h0400; mem[13] = 16'h0041; mem[14] = 16'h0401;
    repeat (2) @(negedge clk);
    t_reset();
    t_basic();
    t_nonbasic();
    t_stall();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule